// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This block owns a small word memory and serves one requester through a valid/ready handshake. Each request names an operation, a word address and up to two operands. Plain reads and writes finish in one cycle. Test-and-set, swap, compare-and-swap and store-conditional finish in two cycles. In the first cycle the unit captures the old word. In the second it performs the conditional write and returns either the old word or a success flag.

No other request is accepted while an atomic operation is in flight, so its read and its write form one indivisible step. A one-entry reservation supports load-linked / store-conditional sequences. Load-linked arms the reservation. Any later write that lands on the reserved word disarms it. Every store-conditional disarms it once it completes.

Software retries a store-conditional that returns zero. Compare-and-swap reports its outcome as a flag.

Top module: `amo_unit`

## Requirements
- R1: After reset every memory word reads zero, no reservation is armed (a store-conditional fails), and `req_ready` is high once the internal reset synchronizer has released.
- R2: Opcodes on `req_op` are: 0 read, 1 write, 2 test-and-set, 3 swap, 4 compare-and-swap, 5 load-linked, 6 store-conditional, and 7 behaves as read. A read returns the addressed word. A write stores `req_opa` and returns the previous word. Either response appears with `rsp_valid` one cycle after acceptance.
- R3: Test-and-set returns the previous word and leaves the value 1 in it.
- R4: Swap stores `req_opa` and returns the previous word.
- R5: Compare-and-swap stores `req_opb` and returns 1 when `req_opa` equals the stored word. Otherwise it leaves memory unchanged and returns 0.
- R6: Load-linked returns the word and arms the reservation on its address. A store-conditional to that address while the reservation is armed stores `req_opa` and returns 1.
- R7: A store-conditional with no armed reservation, or with an armed reservation on a different address, writes nothing and returns 0.
- R8: A write, test-and-set, swap or successful compare-and-swap to the reserved address disarms the reservation. A failed compare-and-swap, and any access to another address, leave it armed.
- R9: Every store-conditional disarms the reservation, whether or not it succeeds.
- R10: An atomic operation holds `req_ready` low for the one cycle after acceptance. It raises `rsp_valid` two cycles after acceptance, and a request held valid during that cycle is accepted only afterwards and observes the atomic's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request this cycle |
| req_op | input | 3 | Operation code (see R2) |
| req_addr | input | ADDR_W | Word address |
| req_opa | input | DATA_W | First operand: store value, or compare value for compare-and-swap |
| req_opb | input | DATA_W | Second operand: new value for compare-and-swap |
| rsp_valid | output | 1 | Response valid for one cycle |
| rsp_data | output | DATA_W | Old word, or success flag for compare-and-swap and store-conditional |

## Verification
Two functions meet in one cycle. In the completion cycle of a store-conditional, the success decision reads the reservation and the same edge disarms it. The bench provokes this with back-to-back store-conditionals after one load-linked, and judges it by the second one returning 0 and leaving the word untouched.

A second meeting point is a request held valid during an atomic's stall cycle, where acceptance and the atomic write-back compete. The bench checks that `req_ready` is low there and that the held read returns the freshly written value. Random traffic on four addresses mixes all opcodes against a bench model, so that reservations are often broken by neighbouring writes.

// File: rtl/amo_pkg.sv
package amo_pkg;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_TAS   = 3'd2,
    OP_SWAP  = 3'd3,
    OP_CAS   = 3'd4,
    OP_LL    = 3'd5,
    OP_SC    = 3'd6,
    OP_RSVD  = 3'd7
  } amo_op_e;

  function automatic logic op_is_atomic(input logic [2:0] op);
    return (op == OP_TAS) || (op == OP_SWAP) || (op == OP_CAS) || (op == OP_SC);
  endfunction

endpackage

// File: rtl/amo_mem.sv
module amo_mem #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic word_en;
    assign word_en = we && (waddr == ADDR_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        words[g] <= '0;
      end else if (word_en) begin
        words[g] <= wdata;
      end
    end
  end

  assign rdata = words[raddr];

endmodule

// File: rtl/amo_resv.sv
module amo_resv #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [ADDR_W-1:0] set_addr,
  input  logic              drop_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              hit,
  output logic              armed
);

  logic              vld_q, vld_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    vld_d  = vld_q;
    addr_d = addr_q;
    if (set_en) begin
      vld_d  = 1'b1;
      addr_d = set_addr;
    end else if (drop_en) begin
      vld_d = 1'b0;
    end else if (wr_en && (wr_addr == addr_q)) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      vld_q  <= vld_d;
      addr_q <= addr_d;
    end
  end

  assign hit   = vld_q && (addr_q == chk_addr);
  assign armed = vld_q;

endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  amo_op_e           op,
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              resv_hit,
  output logic              we,
  output logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] result
);

  logic match;
  assign match = (old_word == opa);

  always_comb begin
    we     = 1'b0;
    wdata  = opa;
    result = old_word;
    unique case (op)
      OP_TAS: begin
        we    = 1'b1;
        wdata = DATA_W'(1);
      end
      OP_SWAP: we = 1'b1;
      OP_CAS: begin
        we     = match;
        wdata  = opb;
        result = DATA_W'(match);
      end
      OP_SC: begin
        we     = resv_hit;
        result = DATA_W'(resv_hit);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_opa,
  input  logic [DATA_W-1:0] req_opb,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  // request capture for the two-cycle atomic path
  logic              busy_q, busy_d;
  logic [2:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] opa_q, opb_q, old_q;
  logic              accept, take_atomic;

  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;

  logic              alu_we;
  logic [DATA_W-1:0] alu_wdata, alu_result;
  logic              resv_hit, resv_vld;

  logic              rsp_valid_d;
  logic [DATA_W-1:0] rsp_data_d;

  assign req_ready   = rst_ok && !busy_q;
  assign accept      = req_valid && req_ready;
  assign take_atomic = accept && op_is_atomic(req_op);

  always_comb begin
    busy_d = busy_q;
    if (busy_q)           busy_d = 1'b0;
    else if (take_atomic) busy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) busy_q <= 1'b0;
    else         busy_q <= busy_d;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      op_q   <= 3'd0;
      addr_q <= '0;
      opa_q  <= '0;
      opb_q  <= '0;
      old_q  <= '0;
    end else if (take_atomic) begin
      op_q   <= req_op;
      addr_q <= req_addr;
      opa_q  <= req_opa;
      opb_q  <= req_opb;
      old_q  <= mem_rdata;
    end
  end

  // single write port: atomic write-back in the busy cycle, plain write otherwise
  always_comb begin
    if (busy_q) begin
      mem_we    = alu_we;
      mem_waddr = addr_q;
      mem_wdata = alu_wdata;
    end else begin
      mem_we    = accept && (req_op == OP_WRITE);
      mem_waddr = req_addr;
      mem_wdata = req_opa;
    end
  end

  amo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
    .clk   (clk),
    .rst_n (rst_ok),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (req_addr),
    .rdata (mem_rdata)
  );

  amo_resv #(.ADDR_W(ADDR_W)) u_resv (
    .clk      (clk),
    .rst_n    (rst_ok),
    .set_en   (accept && (req_op == OP_LL)),
    .set_addr (req_addr),
    .drop_en  (busy_q && (op_q == OP_SC)),
    .wr_en    (mem_we),
    .wr_addr  (mem_waddr),
    .chk_addr (addr_q),
    .hit      (resv_hit),
    .armed    (resv_vld)
  );

  amo_alu #(.DATA_W(DATA_W)) u_alu (
    .op       (amo_op_e'(op_q)),
    .old_word (old_q),
    .opa      (opa_q),
    .opb      (opb_q),
    .resv_hit (resv_hit),
    .we       (alu_we),
    .wdata    (alu_wdata),
    .result   (alu_result)
  );

  always_comb begin
    rsp_valid_d = busy_q || (accept && !take_atomic);
    rsp_data_d  = busy_q ? alu_result : mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_data  <= rsp_data_d;
    end
  end

endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk
  import amo_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_op,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic              busy,
  input logic [2:0]        cur_op,
  input logic              resv_vld
);

  logic acc;
  assign acc = req_valid && req_ready;

  AST_ATOMIC_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op_is_atomic(req_op)) |=> (!req_ready && !rsp_valid)); // R10

  AST_ATOMIC_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op_is_atomic(req_op)) |=> ##1 (rsp_valid && req_ready)); // R10

  AST_PLAIN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !op_is_atomic(req_op)) |=> rsp_valid); // R2

  AST_LL_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == OP_LL) |=> resv_vld); // R6

  AST_SC_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_op == OP_SC) |=> !resv_vld); // R9

  AST_SC_UNARMED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_op == OP_SC && !resv_vld) |=> (rsp_valid && rsp_data == '0)); // R7

  AST_CAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_op == OP_CAS) |=> (rsp_data <= DATA_W'(1))); // R5

endmodule

bind amo_unit amo_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_op    (req_op),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .busy      (busy_q),
  .cur_op    (op_q),
  .resv_vld  (resv_vld)
);

// File: tb/amo_unit_test.sv
`timescale 1ns/1ps
module amo_unit_test;

  localparam int DW = 32;
  localparam int DEPTH = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [2:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_opa, req_opb;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] model [DEPTH];
  logic          m_rv;
  logic [AW-1:0] m_ra;

  always #10 clk = ~clk;

  amo_unit #(.DATA_W(DW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_opa(req_opa), .req_opb(req_opb),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic check(input logic ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic is_atom(input logic [2:0] op);
    return op == 3'd2 || op == 3'd3 || op == 3'd4 || op == 3'd6;
  endfunction

  function automatic string def_tag(input logic [2:0] op);
    case (op)
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R6/R7";
      default: return "R2";
    endcase
  endfunction

  // expected response and model update, from the requirements
  function automatic logic [DW-1:0] model_apply(input logic [2:0] op, input logic [AW-1:0] a,
                                                input logic [DW-1:0] x, input logic [DW-1:0] y);
    logic [DW-1:0] old = model[a];
    logic hit = m_rv && (m_ra == a);
    case (op)
      3'd1: begin model[a] = x; if (hit) m_rv = 1'b0; return old; end
      3'd2: begin model[a] = 1; if (hit) m_rv = 1'b0; return old; end
      3'd3: begin model[a] = x; if (hit) m_rv = 1'b0; return old; end
      3'd4: begin
        if (old == x) begin model[a] = y; if (hit) m_rv = 1'b0; return 1; end
        return 0;
      end
      3'd5: begin m_rv = 1'b1; m_ra = a; return old; end
      3'd6: begin
        m_rv = 1'b0;
        if (hit) begin model[a] = x; return 1; end
        return 0;
      end
      default: return old;
    endcase
  endfunction

  task automatic run_op(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] x,
                        input logic [DW-1:0] y, input string tag);
    logic [DW-1:0] exp;
    string t = (tag == "") ? def_tag(op) : tag;
    exp = model_apply(op, a, x, y);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_opa = x; req_opb = y;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (is_atom(op)) begin
      check(!req_ready && !rsp_valid, "R10 stall", {30'd0, req_ready, rsp_valid}, 0);
      @(negedge clk);
      check(req_ready, "R10 ready back", {31'd0, req_ready}, 1);
    end
    check(rsp_valid, {t, " rsp_valid"}, {31'd0, rsp_valid}, 1);
    check(rsp_data == exp, t, rsp_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] old9;
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    m_rv = 1'b0; m_ra = '0;
    req_valid = 1'b0; req_op = '0; req_addr = '0; req_opa = '0; req_opb = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(req_ready && !rsp_valid, "R1 idle after reset", {30'd0, req_ready, rsp_valid}, 2);
    for (int i = 0; i < DEPTH; i++) run_op(3'd0, AW'(i), 0, 0, "R1 zero word");
    run_op(3'd6, 4'd0, 32'hDEAD, 0, "R1 no reservation");
    run_op(3'd0, 4'd0, 0, 0, "R1 word untouched");

    // R2 plain ops, opcode 7
    run_op(3'd1, 4'd3, 32'hA5, 0, "R2 write");
    run_op(3'd0, 4'd3, 0, 0, "R2 read");
    run_op(3'd7, 4'd3, 0, 0, "R2 opcode 7");
    // R3
    run_op(3'd2, 4'd3, 0, 0, "R3 tas old");
    run_op(3'd0, 4'd3, 0, 0, "R3 tas leaves 1");
    run_op(3'd2, 4'd3, 0, 0, "R3 tas again");
    // R4
    run_op(3'd3, 4'd5, 32'h1234, 0, "R4 swap");
    run_op(3'd0, 4'd5, 0, 0, "R4 swap stored");
    // R5
    run_op(3'd4, 4'd5, 32'h1234, 32'h55, "R5 cas hit");
    run_op(3'd4, 4'd5, 32'h1234, 32'h66, "R5 cas miss");
    run_op(3'd0, 4'd5, 0, 0, "R5 cas miss unchanged");
    // R6 and R9 back-to-back store-conditionals
    run_op(3'd5, 4'd6, 0, 0, "R6 ll");
    run_op(3'd6, 4'd6, 32'h77, 0, "R6 sc success");
    run_op(3'd6, 4'd6, 32'h88, 0, "R9 second sc fails");
    run_op(3'd0, 4'd6, 0, 0, "R9 word keeps first sc");
    // R8 reservation survival and loss
    run_op(3'd5, 4'd6, 0, 0, "R8 ll");
    run_op(3'd1, 4'd7, 32'h9, 0, "R8 other addr write");
    run_op(3'd4, 4'd6, 32'hFFFF, 1, "R8 failed cas");
    run_op(3'd6, 4'd6, 32'h99, 0, "R8 reservation survives");
    run_op(3'd5, 4'd6, 0, 0, "R8 ll");
    run_op(3'd1, 4'd6, 32'h42, 0, "R8 write same addr");
    run_op(3'd6, 4'd6, 32'hBB, 0, "R8 sc after write");
    run_op(3'd0, 4'd6, 0, 0, "R8 word keeps write");
    run_op(3'd5, 4'd6, 0, 0, "R8 ll");
    run_op(3'd2, 4'd6, 0, 0, "R8 tas");
    run_op(3'd6, 4'd6, 32'hCC, 0, "R8 sc after tas");
    run_op(3'd5, 4'd6, 0, 0, "R8 ll");
    run_op(3'd3, 4'd6, 32'h5, 0, "R8 swap");
    run_op(3'd6, 4'd6, 32'hCC, 0, "R8 sc after swap");
    run_op(3'd5, 4'd6, 0, 0, "R8 ll");
    run_op(3'd4, 4'd6, 32'h5, 32'h6, "R8 cas hit");
    run_op(3'd6, 4'd6, 32'hCC, 0, "R8 sc after cas");
    // R7 wrong address, then R9 the failed sc dropped it
    run_op(3'd5, 4'd6, 0, 0, "R7 ll");
    run_op(3'd6, 4'd7, 32'h1, 0, "R7 sc other addr");
    run_op(3'd0, 4'd7, 0, 0, "R7 other word unchanged");
    run_op(3'd6, 4'd6, 32'h1, 0, "R9 failed sc dropped reservation");

    // R10: read held valid through the stall cycle of a test-and-set
    old9 = model_apply(3'd2, 4'd9, 0, 0);
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd2; req_addr = 4'd9;
    @(negedge clk);
    req_op = 3'd0;
    check(!req_ready, "R10 held request stalls", {31'd0, req_ready}, 0);
    @(negedge clk);
    check(rsp_valid && rsp_data == old9, "R10 tas response", rsp_data, old9);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && rsp_data == 1, "R10 held read sees write", rsp_data, 1);

    // random mix on few addresses
    for (int n = 0; n < 400; n++) begin
      logic [2:0] op = 3'($urandom % 8);
      logic [AW-1:0] a = AW'($urandom % 4);
      logic [DW-1:0] x = ($urandom % 2) ? model[a] : DW'($urandom % 8);
      logic [DW-1:0] y = $urandom;
      run_op(op, a, x, y, "");
    end

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule